// File: doc/BRIEF.md
# Multi-Port Set/Clear GPIO Bank

This block is a register-mapped general-purpose I/O bank that serves three ordinary bidirectional ports and one irregular mixed port. Every ordinary pin has a direction bit and an output latch. The pin drives its pad enable from the direction bit and its pad data from the latch. Its level reads back through a two-flop synchronizer. Software changes state with write-one-to-set and write-one-to-clear registers, so one bit can change without a read-modify-write, and a separate state register shows the current value.

The mixed port shares registers across three kinds of pins. Six bidirectional pins take their output level from the upper bits of the mixed port's output registers. They take their direction from the upper bits of port 2's direction registers, and their input levels appear at scattered positions of the mixed input register. The same registers also carry 22 input-only pins and 24 output-only pins. A small pad-function select register with its own set, clear and state addresses completes the map.

The bus is a plain synchronous port carrying a byte address, a write enable and write data. A write takes effect at the clock edge. Read data is a combinational function of the address and the current state.

Top module: `gpio_bank`

Address map (byte address: register). Mixed port: 0x00 input, 0x04 out set, 0x08 out clear, 0x0C out state. Port 2: 0x10 dir set, 0x14 dir clear, 0x18 dir state, 0x1C input, 0x20 out set, 0x24 out clear. Pad-function select: 0x28 set, 0x2C clear, 0x30 state. Port 0 has its input at 0x40 and port 1 at 0x60. Each of these two ports then continues at its base with out set +0x04, out clear +0x08, out state +0x0C, dir set +0x10, dir clear +0x14 and dir state +0x18.

## Requirements
- R1: While rstN is low, and after it rises, every direction bit, output latch and select bit is 0, so every pad enable and pad output is 0 and every state register reads 0.
- R2: A write to a set address forces to 1 each target bit whose write-data bit is 1 and leaves the other bits unchanged. The new value is visible from the next cycle.
- R3: A write to a clear address forces to 0 each target bit whose write-data bit is 1 and leaves the other bits unchanged. The new value is visible from the next cycle.
- R4: Set and clear addresses read 0, and so does every address not in the map. Write-data bits beyond a register's width are ignored and read back 0.
- R5: For ports 0, 1 and 2, each pad enable equals its direction bit (1 means output) and each pad output equals its output latch. Port widths are 8, 24 and 13 pins. Direction state and output state read back at bit positions equal to the pin number.
- R6: Mixed bidirectional pin j (0..5) drives its output from bit 25+j of the mixed output registers (0x04/0x08/0x0C). Its enable comes from bit 25+j of port 2's direction registers (0x10/0x14/0x18).
- R7: The mixed input register at 0x00 holds bidirectional pins 0..4 at bits 10..14 and pin 5 at bit 24. It holds input-only pins 0..9 at bits 0..9, pins 10..18 at bits 15..23 and pins 19..21 at bits 25..27. Bits 28..31 read 0.
- R8: Output-only pin i (0..23) is driven from bit i of the mixed output registers. Bits 24 and 31 of those registers do not exist and read 0.
- R9: Each input register shows the pad level that was present two rising edges earlier. The level is sampled through two flops, so it is not visible after one edge.
- R10: The 8-bit pad-function select output follows its set/clear registers at 0x28/0x2C and reads back at 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| p0In | input | 8 | Port 0 pad levels |
| p0Out | output | 8 | Port 0 pad data |
| p0Oe | output | 8 | Port 0 pad enables |
| p1In | input | 24 | Port 1 pad levels |
| p1Out | output | 24 | Port 1 pad data |
| p1Oe | output | 24 | Port 1 pad enables |
| p2In | input | 13 | Port 2 pad levels |
| p2Out | output | 13 | Port 2 pad data |
| p2Oe | output | 13 | Port 2 pad enables |
| mixIoIn | input | 6 | Mixed bidirectional pad levels |
| mixIoOut | output | 6 | Mixed bidirectional pad data |
| mixIoOe | output | 6 | Mixed bidirectional pad enables |
| mixInOnly | input | 22 | Mixed input-only pad levels |
| mixOutOnly | output | 24 | Mixed output-only pad data |
| altSel | output | 8 | Pad-function select bits |

## Verification
The assertions assume that rstN is low on the first clock edge and that the bus presents at most one address per cycle. The synchronizer property applies only after two reset-free edges, because pad inputs during reset are not constrained. The stimulus changes the bus and the pads only on falling clock edges and keeps every pad low while reset is active. It therefore never presents a value in the same instant that the design samples it. The bench sweeps every bit of every register and pad one at a time, then layers pseudo-random set and clear patterns on top. It predicts each read from its own model of the map and of the scattered bit layout.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int P0_W = 8;
  localparam int P1_W = 24;
  localparam int P2_W = 13;
  localparam int BIDI_W = 6;
  localparam int BIDI_LSB = 25;
  localparam int GPI_W = 22;
  localparam int GPO_W = 24;
  localparam int MUX_W = 8;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_ORD = 2;  // ports sharing the regular block layout
  localparam int IN_W = P0_W + P1_W + P2_W + BIDI_W + GPI_W;

  // mixed port and port 2 addresses
  localparam logic [ADDR_W-1:0] A_MIX_IN   = 8'h00;
  localparam logic [ADDR_W-1:0] A_MIX_OSET = 8'h04;
  localparam logic [ADDR_W-1:0] A_MIX_OCLR = 8'h08;
  localparam logic [ADDR_W-1:0] A_MIX_OST  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_P2_DSET  = 8'h10;
  localparam logic [ADDR_W-1:0] A_P2_DCLR  = 8'h14;
  localparam logic [ADDR_W-1:0] A_P2_DST   = 8'h18;
  localparam logic [ADDR_W-1:0] A_P2_IN    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_P2_OSET  = 8'h20;
  localparam logic [ADDR_W-1:0] A_P2_OCLR  = 8'h24;
  localparam logic [ADDR_W-1:0] A_SEL_SET  = 8'h28;
  localparam logic [ADDR_W-1:0] A_SEL_CLR  = 8'h2C;
  localparam logic [ADDR_W-1:0] A_SEL_ST   = 8'h30;
  // regular block: base, stride and offsets
  localparam int ORD_BASE = 'h40;
  localparam int ORD_STRIDE = 'h20;
  localparam int OFF_IN = 'h00, OFF_OSET = 'h04, OFF_OCLR = 'h08, OFF_OST = 'h0C;
  localparam int OFF_DSET = 'h10, OFF_DCLR = 'h14, OFF_DST = 'h18;

  typedef enum logic [3:0] {
    RD_ZERO, RD_MIX_IN, RD_MIX_OST, RD_P2_DST, RD_P2_IN, RD_SEL_ST,
    RD_P0_IN, RD_P0_OST, RD_P0_DST, RD_P1_IN, RD_P1_OST, RD_P1_DST
  } rdSel_e;

  // index 0/1: ordinary ports, 2: port 2, 3: mixed port
  typedef struct packed {
    logic [3:0] outSet;
    logic [3:0] outClr;
    logic [2:0] dirSet;
    logic [2:0] dirClr;
    logic       selSet;
    logic       selClr;
    rdSel_e     rdSel;
  } strobe_t;

  function automatic logic [DATA_W-1:0] applySetClr(input logic [DATA_W-1:0] cur,
                                                    input logic doSet, input logic doClr,
                                                    input logic [DATA_W-1:0] wd);
    if (doSet) return cur | wd;
    if (doClr) return cur & ~wd;
    return cur;
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = RD_ZERO;
    case (busAddr)
      A_MIX_IN:   stb.rdSel = RD_MIX_IN;
      A_MIX_OSET: stb.outSet[3] = busWe;
      A_MIX_OCLR: stb.outClr[3] = busWe;
      A_MIX_OST:  stb.rdSel = RD_MIX_OST;
      A_P2_DSET:  stb.dirSet[2] = busWe;
      A_P2_DCLR:  stb.dirClr[2] = busWe;
      A_P2_DST:   stb.rdSel = RD_P2_DST;
      A_P2_IN:    stb.rdSel = RD_P2_IN;
      A_P2_OSET:  stb.outSet[2] = busWe;
      A_P2_OCLR:  stb.outClr[2] = busWe;
      A_SEL_SET:  stb.selSet = busWe;
      A_SEL_CLR:  stb.selClr = busWe;
      A_SEL_ST:   stb.rdSel = RD_SEL_ST;
      default: ;
    endcase
    for (int k = 0; k < NUM_ORD; k++) begin
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_IN))
        stb.rdSel = (k == 0) ? RD_P0_IN : RD_P1_IN;
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_OST))
        stb.rdSel = (k == 0) ? RD_P0_OST : RD_P1_OST;
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_DST))
        stb.rdSel = (k == 0) ? RD_P0_DST : RD_P1_DST;
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_OSET)) stb.outSet[k] = busWe;
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_OCLR)) stb.outClr[k] = busWe;
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_DSET)) stb.dirSet[k] = busWe;
      if (busAddr == ADDR_W'(ORD_BASE + k * ORD_STRIDE + OFF_DCLR)) stb.dirClr[k] = busWe;
    end
  end
endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [IN_W-1:0]   padIn,
  output logic [P0_W-1:0]   dir0, out0,
  output logic [P1_W-1:0]   dir1, out1,
  output logic [P2_W-1:0]   dir2, out2,
  output logic [BIDI_W-1:0] dirB, outB,
  output logic [GPO_W-1:0]  gpo,
  output logic [MUX_W-1:0]  sel
);
  localparam int OFS_P1 = P0_W;
  localparam int OFS_P2 = OFS_P1 + P1_W;
  localparam int OFS_BI = OFS_P2 + P2_W;
  localparam int OFS_GI = OFS_BI + BIDI_W;

  logic [IN_W-1:0] syncQ [SYNC_STAGES];
  logic [IN_W-1:0] inSync;
  logic [DATA_W-1:0] bidiWd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign inSync = syncQ[SYNC_STAGES-1];

  // mixed bidirectional bits sit high in their shared registers
  assign bidiWd = DATA_W'(busWdata[BIDI_LSB +: BIDI_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dir0 <= '0; out0 <= '0; dir1 <= '0; out1 <= '0;
      dir2 <= '0; out2 <= '0; dirB <= '0; outB <= '0;
      gpo <= '0; sel <= '0;
    end else begin
      dir0 <= P0_W'(applySetClr(DATA_W'(dir0), stb.dirSet[0], stb.dirClr[0], busWdata));
      out0 <= P0_W'(applySetClr(DATA_W'(out0), stb.outSet[0], stb.outClr[0], busWdata));
      dir1 <= P1_W'(applySetClr(DATA_W'(dir1), stb.dirSet[1], stb.dirClr[1], busWdata));
      out1 <= P1_W'(applySetClr(DATA_W'(out1), stb.outSet[1], stb.outClr[1], busWdata));
      dir2 <= P2_W'(applySetClr(DATA_W'(dir2), stb.dirSet[2], stb.dirClr[2], busWdata));
      out2 <= P2_W'(applySetClr(DATA_W'(out2), stb.outSet[2], stb.outClr[2], busWdata));
      dirB <= BIDI_W'(applySetClr(DATA_W'(dirB), stb.dirSet[2], stb.dirClr[2], bidiWd));
      outB <= BIDI_W'(applySetClr(DATA_W'(outB), stb.outSet[3], stb.outClr[3], bidiWd));
      gpo  <= GPO_W'(applySetClr(DATA_W'(gpo), stb.outSet[3], stb.outClr[3], busWdata));
      sel  <= MUX_W'(applySetClr(DATA_W'(sel), stb.selSet, stb.selClr, busWdata));
    end
  end

  always_comb begin
    logic [BIDI_W-1:0] bi;
    logic [GPI_W-1:0]  gi;
    bi = inSync[OFS_BI +: BIDI_W];
    gi = inSync[OFS_GI +: GPI_W];
    case (stb.rdSel)
      RD_MIX_IN:  busRdata = {4'b0, gi[21:19], bi[5], gi[18:10], bi[4:0], gi[9:0]};
      RD_MIX_OST: busRdata = {1'b0, outB, 1'b0, gpo};
      RD_P2_DST:  busRdata = {1'b0, dirB, 12'b0, dir2};
      RD_P2_IN:   busRdata = DATA_W'(inSync[OFS_P2 +: P2_W]);
      RD_SEL_ST:  busRdata = DATA_W'(sel);
      RD_P0_IN:   busRdata = DATA_W'(inSync[0 +: P0_W]);
      RD_P0_OST:  busRdata = DATA_W'(out0);
      RD_P0_DST:  busRdata = DATA_W'(dir0);
      RD_P1_IN:   busRdata = DATA_W'(inSync[OFS_P1 +: P1_W]);
      RD_P1_OST:  busRdata = DATA_W'(out1);
      RD_P1_DST:  busRdata = DATA_W'(dir1);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [P0_W-1:0]   p0In,
  output logic [P0_W-1:0]   p0Out,
  output logic [P0_W-1:0]   p0Oe,
  input  logic [P1_W-1:0]   p1In,
  output logic [P1_W-1:0]   p1Out,
  output logic [P1_W-1:0]   p1Oe,
  input  logic [P2_W-1:0]   p2In,
  output logic [P2_W-1:0]   p2Out,
  output logic [P2_W-1:0]   p2Oe,
  input  logic [BIDI_W-1:0] mixIoIn,
  output logic [BIDI_W-1:0] mixIoOut,
  output logic [BIDI_W-1:0] mixIoOe,
  input  logic [GPI_W-1:0]  mixInOnly,
  output logic [GPO_W-1:0]  mixOutOnly,
  output logic [MUX_W-1:0]  altSel
);
  strobe_t stb;

  gpio_bank_ctrl i_ctrl (
    .busAddr(busAddr), .busWe(busWe), .stb(stb)
  );

  gpio_bank_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .busRdata(busRdata),
    .padIn({mixInOnly, mixIoIn, p2In, p1In, p0In}),
    .dir0(p0Oe), .out0(p0Out), .dir1(p1Oe), .out1(p1Out),
    .dir2(p2Oe), .out2(p2Out), .dirB(mixIoOe), .outB(mixIoOut),
    .gpo(mixOutOnly), .sel(altSel)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic        busWe,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [7:0]  p0In,
  input logic [7:0]  p0Out,
  input logic [7:0]  p0Oe,
  input logic [23:0] p1Oe,
  input logic [12:0] p2Oe,
  input logic [5:0]  mixIoOe,
  input logic [23:0] mixOutOnly
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (p0Oe == '0 && p1Oe == '0 && p2Oe == '0 && mixIoOe == '0 && mixOutOnly == '0));

  assert_set_forces_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'h44) |=> ((p0Out & $past(busWdata[7:0])) == $past(busWdata[7:0])));

  assert_clear_forces_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'h48) |=> ((p0Out & $past(busWdata[7:0])) == 8'h00));

  assert_strobe_reads_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h04 || busAddr == 8'h14 || busAddr == 8'h44 || busAddr == 8'h68)
      |-> busRdata == 32'h0);

  assert_enable_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(p0Oe) && $stable(p1Oe) && $stable(p2Oe) && $stable(mixIoOe)));

  assert_bidi_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'h10) |=> ((mixIoOe & $past(busWdata[30:25])) == $past(busWdata[30:25])));

  assert_mix_in_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h00) |-> busRdata[31:28] == 4'h0);

  assert_gpo_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'h04) |=> ((mixOutOnly & $past(busWdata[23:0])) == $past(busWdata[23:0])));

  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && busAddr == 8'h40) |-> busRdata[7:0] == $past(p0In, 2));
endmodule

bind gpio_bank gpio_bank_chk i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .p0In(p0In), .p0Out(p0Out), .p0Oe(p0Oe), .p1Oe(p1Oe),
  .p2Oe(p2Oe), .mixIoOe(mixIoOe), .mixOutOnly(mixOutOnly)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr;
  logic busWe;
  logic [31:0] busWdata, busRdata;
  logic [7:0] p0In, p0Out, p0Oe;
  logic [23:0] p1In, p1Out, p1Oe;
  logic [12:0] p2In, p2Out, p2Oe;
  logic [5:0] mixIoIn, mixIoOut, mixIoOe;
  logic [21:0] mixInOnly;
  logic [23:0] mixOutOnly;
  logic [7:0] altSel;

  int nChecks = 0;
  int nErr = 0;

  // bench model of the register state
  logic [31:0] mDir0, mDir1, mDir2, mOut0, mOut1, mOut2, mGpo, mSel;
  logic [5:0] mDirB, mOutB;

  always #4 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .p0In(p0In), .p0Out(p0Out), .p0Oe(p0Oe),
    .p1In(p1In), .p1Out(p1Out), .p1Oe(p1Oe), .p2In(p2In), .p2Out(p2Out), .p2Oe(p2Oe),
    .mixIoIn(mixIoIn), .mixIoOut(mixIoOut), .mixIoOe(mixIoOe),
    .mixInOnly(mixInOnly), .mixOutOnly(mixOutOnly), .altSel(altSel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sc(input logic [31:0] cur, input bit isSet,
                                     input logic [31:0] d, input logic [31:0] mask);
    return (isSet ? (cur | d) : (cur & ~d)) & mask;
  endfunction

  task automatic modelReset();
    mDir0 = 0; mDir1 = 0; mDir2 = 0; mOut0 = 0; mOut1 = 0; mOut2 = 0;
    mGpo = 0; mSel = 0; mDirB = 0; mOutB = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'hFC;
    case (a)
      8'h04: begin mGpo = sc(mGpo, 1, d, 32'hFF_FFFF); mOutB = mOutB | d[30:25]; end
      8'h08: begin mGpo = sc(mGpo, 0, d, 32'hFF_FFFF); mOutB = mOutB & ~d[30:25]; end
      8'h10: begin mDir2 = sc(mDir2, 1, d, 32'h1FFF); mDirB = mDirB | d[30:25]; end
      8'h14: begin mDir2 = sc(mDir2, 0, d, 32'h1FFF); mDirB = mDirB & ~d[30:25]; end
      8'h20: mOut2 = sc(mOut2, 1, d, 32'h1FFF);
      8'h24: mOut2 = sc(mOut2, 0, d, 32'h1FFF);
      8'h28: mSel = sc(mSel, 1, d, 32'hFF);
      8'h2C: mSel = sc(mSel, 0, d, 32'hFF);
      8'h44: mOut0 = sc(mOut0, 1, d, 32'hFF);
      8'h48: mOut0 = sc(mOut0, 0, d, 32'hFF);
      8'h50: mDir0 = sc(mDir0, 1, d, 32'hFF);
      8'h54: mDir0 = sc(mDir0, 0, d, 32'hFF);
      8'h64: mOut1 = sc(mOut1, 1, d, 32'hFF_FFFF);
      8'h68: mOut1 = sc(mOut1, 0, d, 32'hFF_FFFF);
      8'h70: mDir1 = sc(mDir1, 1, d, 32'hFF_FFFF);
      8'h74: mDir1 = sc(mDir1, 0, d, 32'hFF_FFFF);
      default: ;
    endcase
  endtask

  // expected read value, from the requirement text (pads assumed settled)
  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [31:0] r;
    r = 0;
    case (a)
      8'h00: begin
        for (int i = 0; i < 22; i++) r[(i < 10) ? i : ((i < 19) ? i + 5 : i + 6)] = mixInOnly[i];
        for (int j = 0; j < 6; j++) r[(j < 5) ? 10 + j : 24] = mixIoIn[j];
      end
      8'h0C: r = mGpo | (32'(mOutB) << 25);
      8'h18: r = mDir2 | (32'(mDirB) << 25);
      8'h1C: r = 32'(p2In);
      8'h30: r = mSel;
      8'h40: r = 32'(p0In);
      8'h4C: r = mOut0;
      8'h58: r = mDir0;
      8'h60: r = 32'(p1In);
      8'h6C: r = mOut1;
      8'h78: r = mDir1;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic rdChk(input string req, input logic [7:0] a);
    busAddr = a;
    #1;
    chk(req, busRdata, expRead(a));
  endtask

  task automatic padChk(input string req);
    chk({req, " p0Oe"}, 32'(p0Oe), mDir0);
    chk({req, " p0Out"}, 32'(p0Out), mOut0);
    chk({req, " p1Oe"}, 32'(p1Oe), mDir1);
    chk({req, " p1Out"}, 32'(p1Out), mOut1);
    chk({req, " p2Oe"}, 32'(p2Oe), mDir2);
    chk({req, " p2Out"}, 32'(p2Out), mOut2);
    chk("R6 mixIoOe", 32'(mixIoOe), 32'(mDirB));
    chk("R6 mixIoOut", 32'(mixIoOut), 32'(mOutB));
    chk("R8 mixOutOnly", 32'(mixOutOnly), mGpo);
    chk("R10 altSel", 32'(altSel), mSel);
  endtask

  task automatic stateChk(input string req);
    rdChk(req, 8'h58); rdChk(req, 8'h78); rdChk(req, 8'h18);
    rdChk(req, 8'h4C); rdChk(req, 8'h6C); rdChk(req, 8'h0C); rdChk(req, 8'h30);
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    #(8 * 150000);
    nErr++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] pat, pat2;
    logic [7:0] oldP0;
    busAddr = 8'hFC; busWe = 0; busWdata = 0;
    p0In = 0; p1In = 0; p2In = 0; mixIoIn = 0; mixInOnly = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    stateChk("R1 reset state");
    padChk("R1 reset pads");

    // R2/R5/R6: walking-one direction sets on every port
    for (int b = 0; b < 32; b++) begin
      wr(8'h50, 32'h1 << b); wr(8'h70, 32'h1 << b); wr(8'h10, 32'h1 << b);
      rdChk("R2 dir set p0", 8'h58); rdChk("R2 dir set p1", 8'h78);
      rdChk("R6 dir set p2/mix", 8'h18);
      padChk("R5 pads after dir set");
    end
    // R3: clear every other bit
    wr(8'h54, 32'h5555_5555); wr(8'h74, 32'hAAAA_AAAA); wr(8'h14, 32'h5555_5555);
    stateChk("R3 dir clear");
    padChk("R3 pads after dir clear");

    // R2/R3/R8/R10: pseudo-random set and clear patterns on output latches
    pat = 32'hC0DE_1234;
    for (int n = 0; n < 16; n++) begin
      pat = lfsr(pat); pat2 = lfsr(~pat);
      wr(8'h44, pat); wr(8'h64, pat); wr(8'h20, pat); wr(8'h04, pat); wr(8'h28, pat);
      stateChk("R2 out set");
      padChk("R5 pads after out set");
      wr(8'h48, pat2); wr(8'h68, pat2); wr(8'h24, pat2); wr(8'h08, pat2); wr(8'h2C, pat2);
      stateChk("R3 out clear");
      padChk("R5 pads after out clear");
    end

    // R8/R4: all-ones set on mixed output, bits 24 and 31 absent
    wr(8'h04, 32'hFFFF_FFFF);
    busAddr = 8'h0C; #1;
    chk("R8 mixed out state all ones", busRdata, 32'h7EFF_FFFF);
    chk("R4 mixed out bits 24/31", busRdata & 32'h8100_0000, 32'h0);
    padChk("R8 pads all ones");

    // R4: strobe and unmapped addresses read zero
    foreach (pat[i]) ;
    for (int i = 0; i < 13; i++) begin
      logic [7:0] a;
      case (i)
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h10; 3: a = 8'h14; 4: a = 8'h20;
        5: a = 8'h24; 6: a = 8'h28; 7: a = 8'h2C; 8: a = 8'h44; 9: a = 8'h70;
        10: a = 8'h34; 11: a = 8'h5C; default: a = 8'hFC;
      endcase
      busAddr = a; #1;
      chk("R4 reads zero", busRdata, 32'h0);
    end

    // R7: one-hot sweep over mixed inputs
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); mixIoIn = 6'h1 << j; mixInOnly = 0;
      repeat (2) @(negedge clk);
      rdChk("R7 mixed bidi input", 8'h00);
    end
    for (int i = 0; i < 22; i++) begin
      @(negedge clk); mixIoIn = 0; mixInOnly = 22'h1 << i;
      repeat (2) @(negedge clk);
      rdChk("R7 mixed input-only", 8'h00);
    end
    @(negedge clk); mixIoIn = 6'h3F; mixInOnly = 22'h3F_FFFF;
    repeat (2) @(negedge clk);
    busAddr = 8'h00; #1;
    chk("R7 mixed input all ones", busRdata, 32'h0FFF_FFFF);

    // R9: ordinary input sweeps and two-edge latency
    for (int b = 0; b < 24; b++) begin
      @(negedge clk); p0In = 8'(32'h1 << b); p1In = 24'h1 << b; p2In = 13'(32'h1 << b);
      repeat (2) @(negedge clk);
      rdChk("R9 p0 input", 8'h40); rdChk("R9 p1 input", 8'h60); rdChk("R9 p2 input", 8'h1C);
    end
    @(negedge clk); p0In = 8'h3C;
    repeat (2) @(negedge clk);
    oldP0 = p0In;
    p0In = 8'hA5; busAddr = 8'h40;
    @(negedge clk); #1;
    chk("R9 not visible after one edge", busRdata, 32'(oldP0));
    @(negedge clk); #1;
    chk("R9 visible after two edges", busRdata, 32'hA5);

    // R1: reset in mid-run clears everything
    @(negedge clk); rstN = 1'b0;
    p0In = 0; p1In = 0; p2In = 0; mixIoIn = 0; mixInOnly = 0;
    repeat (2) @(negedge clk);
    modelReset();
    #1;
    padChk("R1 pads during reset");
    rstN = 1'b1;
    @(negedge clk);
    stateChk("R1 state after second reset");
    rdChk("R1 input after reset", 8'h00);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule